// File: doc/BRIEF.md
# Saturating Auto-Increment Register Pointer

This block is the byte-level register access front end that sits behind a two-wire serial slave. The serial layer below it reports transaction starts (including repeated starts) with their direction, stops, bytes received from the master, and requests for a byte to send. The front end keeps one stored command byte that serves as the register pointer for both writes and reads. In a write transaction the first byte loads that pointer, and every later byte is written to the register it selects. A read transaction carries no address byte: it returns bytes starting at the stored pointer.

After every data byte, written or read, the pointer moves to the next register. It stops at the last implemented address and never wraps back to zero. The pointer survives stops and repeated starts, so a master that wants to check what it wrote must send the command byte again. Addresses that are not implemented cannot be written. Reading one returns zero, and the pointer still advances by the normal rule.

The block drives the address, write data and write strobe of an external register file, and takes that file's combinational read data.

Top module: `cmd_ptr_frontend`

## Requirements
- R1: In the cycle after reset is released, the pointer (`rf_addr`) is 0x00 and `rd_valid` is low. A read before any command byte returns register 0x00.
- R2: In a write transaction, the first byte received after the start loads the pointer and writes no register. Each later byte is written to the register at the pointer.
- R3: After each data byte written or read while the pointer is below LAST_ADDR (default 0x26), the pointer rises by exactly one.
- R4: While the pointer is at or above LAST_ADDR, data bytes leave it unchanged. Further writes all land on LAST_ADDR, and the pointer never wraps to 0x00.
- R5: The first byte of a read transaction comes from the register at the stored pointer, and the following bytes come from consecutive registers.
- R6: Stops, repeated starts and idle cycles leave the pointer unchanged. Only a command byte or a reset changes it other than by stepping.
- R7: `rf_we` is never asserted for an unimplemented address. The unimplemented addresses are those above LAST_ADDR, plus every address at or below it whose bit in IMPL_MAP is 0 (by default 0x0E, 0x0F and 0x1C). The register file contents at such addresses stay unchanged.
- R8: A read of an unimplemented address returns 0x00 and still follows the R3/R4 step rule.
- R9: Read data appears on `rd_data` with `rd_valid` high for exactly one cycle, one cycle after the `rd_req` cycle.
- R10: Bytes received outside a write transaction and byte requests outside a read transaction are ignored. They cause no write, no `rd_valid` and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xact_start | input | 1 | Start or repeated-start pulse after the slave address is matched |
| xact_read | input | 1 | Direction of the starting transaction (1 = read), valid with `xact_start` |
| xact_stop | input | 1 | Stop pulse; ends the transaction |
| wr_byte_valid | input | 1 | A byte from the master is available |
| wr_byte | input | BYTE_W | Byte from the master |
| rd_req | input | 1 | The serial layer needs the next byte to send |
| rd_valid | output | 1 | `rd_data` holds the answer to the previous `rd_req` |
| rd_data | output | BYTE_W | Byte returned to the master |
| rf_addr | output | BYTE_W | Register file address (the current pointer) |
| rf_wdata | output | BYTE_W | Register file write data |
| rf_we | output | 1 | Register file write strobe |
| rf_rdata | input | BYTE_W | Register file combinational read data at `rf_addr` |

## Verification
The bench builds the block with its defaults: 8-bit bytes, LAST_ADDR of 0x26, and an implementation map with holes at 0x0E, 0x0F and 0x1C. With these values, holes inside the range, the saturation point, and command loads beyond the last address (0x27 to 0x3F) are all reached by short bursts. The bench's register file stand-in is preloaded with nonzero values everywhere, so a read of a hole only returns 0x00 if the masking works. A final sweep of the stand-in compares every address against the expected contents, which shows whether any blocked write leaked through.

// File: rtl/cmd_ptr_pkg.sv
// Package: shared types for the command-pointer front end.
// Assumes nothing beyond IEEE 1800-2017.
package cmd_ptr_pkg;

    // Transaction phase seen by the sequencer.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CMD   = 2'd1,
        PH_WDATA = 2'd2,
        PH_READ  = 2'd3
    } phase_e;

endpackage

// File: rtl/cmd_ptr_seq.sv
// Module: cmd_ptr_seq
// Tracks the transaction phase. It turns raw byte events into three
// strobes: command load, data write and data read.
// Assumes that start, stop and byte events never fall in the same cycle.
// Any overlap is resolved in favour of the framing event.
module cmd_ptr_seq
    import cmd_ptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xact_start,
    input  logic xact_read,
    input  logic xact_stop,
    input  logic wr_byte_valid,
    input  logic rd_req,
    output logic cmd_load,
    output logic data_wr,
    output logic data_rd
);

    phase_e phase;
    logic   framing;

    assign framing = xact_start | xact_stop;

    // Phase register: a start selects the direction, a stop returns to idle,
    // and the first write byte moves from command to data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else if (xact_stop) begin
            phase <= PH_IDLE;
        end else if (xact_start) begin
            phase <= xact_read ? PH_READ : PH_CMD;
        end else if (phase == PH_CMD && wr_byte_valid) begin
            phase <= PH_WDATA;
        end
    end

    // Strobe decode: byte events count only in the matching phase.
    always_comb begin
        cmd_load = !framing && wr_byte_valid && (phase == PH_CMD);
        data_wr  = !framing && wr_byte_valid && (phase == PH_WDATA);
        data_rd  = !framing && rd_req        && (phase == PH_READ);
    end

endmodule

// File: rtl/cmd_ptr_decode.sv
// Module: cmd_ptr_decode
// Decides whether an address is implemented, and whether it is still
// below the saturation point.
// Assumes IMPL_MAP describes at most 64 addresses. Addresses above
// LAST_ADDR are never implemented.
module cmd_ptr_decode #(
    parameter int          BYTE_W    = 8,
    parameter int          LAST_ADDR = 38,
    parameter logic [63:0] IMPL_MAP  = 64'h0000_007F_EFFF_3FFF
) (
    input  logic [BYTE_W-1:0] addr,
    output logic              impl,
    output logic              below_last
);

    localparam int                DEPTH  = 1 << BYTE_W;
    localparam logic [BYTE_W-1:0] LAST_P = BYTE_W'(LAST_ADDR);

    logic [DEPTH-1:0] map_vec;

    // One map bit per address. Anything past the last address, or past the map, is absent.
    for (genvar i = 0; i < DEPTH; i++) begin : g_map
        if (i <= LAST_ADDR && i < 64) begin : g_in
            assign map_vec[i] = IMPL_MAP[i];
        end else begin : g_out
            assign map_vec[i] = 1'b0;
        end
    end

    // Look up the current address and compare it with the last address.
    always_comb begin
        impl       = map_vec[addr];
        below_last = (addr < LAST_P);
    end

endmodule

// File: rtl/cmd_ptr_reg.sv
// Module: cmd_ptr_reg
// Holds the command byte that serves as the register pointer. It loads
// on a command byte and steps by one while below the last address.
// Assumes cmd_load and step are never high together.
module cmd_ptr_reg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              step,
    input  logic              below_last,
    output logic [BYTE_W-1:0] ptr
);

    // Pointer update: reset to zero, load a command byte, or saturating step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (cmd_load) begin
            ptr <= load_val;
        end else if (step && below_last) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/cmd_ptr_rdpath.sv
// Module: cmd_ptr_rdpath
// Captures the byte returned for a read request. Unimplemented
// addresses read as zero.
// Assumes the register file read data is combinational on the address.
module cmd_ptr_rdpath #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_rd,
    input  logic              impl,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);

    // Read capture: one-cycle valid pulse, data masked for absent registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= data_rd;
            if (data_rd) begin
                rd_data <= impl ? rf_rdata : '0;
            end
        end
    end

endmodule

// File: rtl/cmd_ptr_frontend.sv
// Module: cmd_ptr_frontend (top)
// Register access front end behind a two-wire serial slave. A stored
// command byte is the pointer for writes and reads. It steps after each
// data byte, saturates at LAST_ADDR, and persists across transactions.
// Writes to unimplemented addresses are blocked.
// Assumes the serial layer delivers one event per cycle at most. The
// register file reads combinationally and writes on the clock edge.
module cmd_ptr_frontend #(
    parameter int          BYTE_W    = 8,
    parameter int          LAST_ADDR = 38,
    parameter logic [63:0] IMPL_MAP  = 64'h0000_007F_EFFF_3FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xact_start,
    input  logic              xact_read,
    input  logic              xact_stop,
    input  logic              wr_byte_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rf_addr,
    output logic [BYTE_W-1:0] rf_wdata,
    output logic              rf_we,
    input  logic [BYTE_W-1:0] rf_rdata
);

    logic              cmd_load;
    logic              data_wr;
    logic              data_rd;
    logic              impl;
    logic              below_last;
    logic [BYTE_W-1:0] ptr;

    cmd_ptr_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .xact_start    (xact_start),
        .xact_read     (xact_read),
        .xact_stop     (xact_stop),
        .wr_byte_valid (wr_byte_valid),
        .rd_req        (rd_req),
        .cmd_load      (cmd_load),
        .data_wr       (data_wr),
        .data_rd       (data_rd)
    );

    cmd_ptr_decode #(
        .BYTE_W    (BYTE_W),
        .LAST_ADDR (LAST_ADDR),
        .IMPL_MAP  (IMPL_MAP)
    ) u_dec (
        .addr       (ptr),
        .impl       (impl),
        .below_last (below_last)
    );

    cmd_ptr_reg #(
        .BYTE_W (BYTE_W)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_load   (cmd_load),
        .load_val   (wr_byte),
        .step       (data_wr | data_rd),
        .below_last (below_last),
        .ptr        (ptr)
    );

    cmd_ptr_rdpath #(
        .BYTE_W (BYTE_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_rd  (data_rd),
        .impl     (impl),
        .rf_rdata (rf_rdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Register file drive: address is the pointer, writes gated by the decode.
    always_comb begin
        rf_addr  = ptr;
        rf_wdata = wr_byte;
        rf_we    = data_wr && impl;
    end

endmodule

// File: rtl/cmd_ptr_frontend_chk.sv
// Module: cmd_ptr_frontend_chk
// Property checker for the front end, bound to the top module. It looks
// only at the top-level ports.
// Assumes the same parameter values as the bound instance.
module cmd_ptr_frontend_chk #(
    parameter int          BYTE_W    = 8,
    parameter int          LAST_ADDR = 38,
    parameter logic [63:0] IMPL_MAP  = 64'h0000_007F_EFFF_3FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_byte_valid,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [BYTE_W-1:0] rd_data,
    input logic [BYTE_W-1:0] rf_addr,
    input logic              rf_we
);

    localparam logic [BYTE_W-1:0] LAST_P = BYTE_W'(LAST_ADDR);

    // Independent map lookup by linear search over the map bits.
    function automatic logic in_map(input logic [BYTE_W-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < 64; k++) begin
            if (k <= LAST_ADDR && a == BYTE_W'(k)) begin
                hit = IMPL_MAP[k];
            end
        end
        return hit;
    endfunction

    p_reset_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rf_addr == '0 && !rd_valid));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_addr < LAST_P) |=> (rf_addr == $past(rf_addr) + 1'b1));

    p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_addr >= LAST_P && !wr_byte_valid) |=> (rf_addr == $past(rf_addr)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_byte_valid && !rd_req) |=> $stable(rf_addr));

    p_we_impl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> in_map(rf_addr));

    p_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !in_map($past(rf_addr))) |-> (rd_data == '0));

    p_valid_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

endmodule

bind cmd_ptr_frontend cmd_ptr_frontend_chk #(
    .BYTE_W    (BYTE_W),
    .LAST_ADDR (LAST_ADDR),
    .IMPL_MAP  (IMPL_MAP)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_byte_valid (wr_byte_valid),
    .rd_req        (rd_req),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .rf_addr       (rf_addr),
    .rf_we         (rf_we)
);

// File: tb/sim_cmd_ptr_frontend.sv
// Bench for cmd_ptr_frontend. Directed corner cases are followed by
// seeded random transactions. Expected values come from a bench-side
// model of the requirements.
module sim_cmd_ptr_frontend;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xact_start = 1'b0;
    logic       xact_read = 1'b0;
    logic       xact_stop = 1'b0;
    logic       wr_byte_valid = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rd_req = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [7:0] rf_addr;
    logic [7:0] rf_wdata;
    logic       rf_we;
    logic [7:0] rf_rdata;

    logic       pre_we = 1'b0;
    logic [7:0] pre_a = 8'h00;
    logic [7:0] pre_d = 8'h00;
    logic [7:0] rf_model [256];

    int errors = 0;
    int checks = 0;

    // Expected-state model: 0 idle, 1 command, 2 write data, 3 read.
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr;
    int         exp_ph;

    always #4 clk = ~clk;

    cmd_ptr_frontend u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .xact_start    (xact_start),
        .xact_read     (xact_read),
        .xact_stop     (xact_stop),
        .wr_byte_valid (wr_byte_valid),
        .wr_byte       (wr_byte),
        .rd_req        (rd_req),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rf_addr       (rf_addr),
        .rf_wdata      (rf_wdata),
        .rf_we         (rf_we),
        .rf_rdata      (rf_rdata)
    );

    // Register file stand-in: preload port plus the block's write port.
    always @(posedge clk) begin
        if (pre_we) rf_model[pre_a] <= pre_d;
        else if (rf_we) rf_model[rf_addr] <= rf_wdata;
    end
    assign rf_rdata = rf_model[rf_addr];

    function automatic logic is_impl(input logic [7:0] a);
        return (a <= 8'h26) && (a != 8'h0E) && (a != 8'h0F) && (a != 8'h1C);
    endfunction

    function automatic logic [7:0] next_ptr(input logic [7:0] p);
        return (p < 8'h26) ? p + 8'd1 : p;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_x(input logic rd);
        xact_start = 1'b1;
        xact_read = rd;
        @(negedge clk);
        xact_start = 1'b0;
        xact_read = 1'b0;
        exp_ph = rd ? 3 : 1;
    endtask

    task automatic stop_x();
        xact_stop = 1'b1;
        @(negedge clk);
        xact_stop = 1'b0;
        exp_ph = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        wr_byte_valid = 1'b1;
        wr_byte = b;
        @(negedge clk);
        wr_byte_valid = 1'b0;
        if (exp_ph == 1) begin
            exp_ptr = b;
            exp_ph = 2;
        end else if (exp_ph == 2) begin
            if (is_impl(exp_ptr)) exp_mem[exp_ptr] = b;
            exp_ptr = next_ptr(exp_ptr);
        end
    endtask

    // Request one byte; the answer is due one cycle later (R9).
    task automatic read_one(input string req);
        logic [7:0] e;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        if (exp_ph == 3) begin
            e = is_impl(exp_ptr) ? exp_mem[exp_ptr] : 8'h00;
            chk({req, " R9 valid"}, rd_valid, 1);
            chk({req, " data"}, rd_data, e);
            exp_ptr = next_ptr(exp_ptr);
        end else begin
            chk({req, " R10 no valid"}, rd_valid, 0);
        end
        @(negedge clk);
        chk({req, " R9 single pulse"}, rd_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        exp_ptr = 8'h00;
        exp_ph = 0;
        // Preload every location with a nonzero value while in reset.
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            pre_we = 1'b1;
            pre_a = 8'(i);
            pre_d = 8'(($urandom % 255) + 1);
            exp_mem[i] = pre_d;
            @(negedge clk);
        end
        pre_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, and a read before any command starts at 0x00.
        chk("R1 rd_valid after reset", rd_valid, 0);
        chk("R1 pointer after reset", rf_addr, 8'h00);
        start_x(1);
        read_one("R1 first read at 0x00");
        read_one("R5 consecutive read 0x01");
        stop_x();

        // R2: command byte then data; a readback needs the command again.
        start_x(0);
        send_byte(8'h05);
        chk("R2 command byte writes nothing", rf_model[8'h05], exp_mem[8'h05]);
        send_byte(8'hA1);
        send_byte(8'hB2);
        chk("R2 pointer after two data bytes", rf_addr, 8'h07);
        stop_x();
        start_x(0);
        send_byte(8'h05);
        stop_x();
        start_x(1);
        read_one("R2 readback 0x05");
        chk("R2 value at 0x05", rd_data, 8'hA1);
        read_one("R5 readback 0x06");
        chk("R5 value at 0x06", rd_data, 8'hB2);
        stop_x();

        // R6: repeated start keeps the pointer.
        start_x(0);
        send_byte(8'h10);
        send_byte(8'h3C);
        start_x(1);
        chk("R6 pointer kept over repeated start", rf_addr, 8'h11);
        read_one("R6 read after repeated start");
        stop_x();
        repeat (3) @(negedge clk);
        chk("R6 pointer kept while idle", rf_addr, 8'h12);

        // R4: saturation at 0x26; extra bytes land on 0x26.
        start_x(0);
        send_byte(8'h24);
        send_byte(8'hE1);
        send_byte(8'hE2);
        send_byte(8'hE3);
        send_byte(8'hE4);
        send_byte(8'hE5);
        chk("R4 pointer saturates at 0x26", rf_addr, 8'h26);
        stop_x();
        start_x(1);
        read_one("R4 read at saturation");
        chk("R4 last write wins at 0x26", rd_data, 8'hE5);
        read_one("R4 read stays at 0x26");
        chk("R4 no wrap to 0x00", rf_addr, 8'h26);
        stop_x();

        // R7/R8: holes and beyond-last addresses.
        start_x(0);
        send_byte(8'h0D);
        send_byte(8'h11);
        send_byte(8'h22);
        send_byte(8'h33);
        send_byte(8'h44);
        chk("R7 hole 0x0E untouched", rf_model[8'h0E], exp_mem[8'h0E]);
        chk("R8 pointer steps through holes", rf_addr, 8'h11);
        start_x(0);
        send_byte(8'h0E);
        start_x(1);
        read_one("R8 hole reads zero");
        chk("R8 hole data zero", rd_data, 8'h00);
        read_one("R8 second hole reads zero");
        stop_x();
        start_x(0);
        send_byte(8'h30);
        send_byte(8'h99);
        chk("R7 beyond last untouched", rf_model[8'h30], exp_mem[8'h30]);
        chk("R4 beyond last pointer holds", rf_addr, 8'h30);
        start_x(1);
        read_one("R8 beyond last reads zero");
        stop_x();

        // R10: stray events in the wrong phase.
        send_byte(8'h77);
        chk("R10 idle byte ignored", rf_addr, 8'h30);
        read_one("R10 idle request");
        start_x(0);
        send_byte(8'h02);
        read_one("R10 request in write");
        chk("R10 pointer after stray request", rf_addr, 8'h02);
        start_x(1);
        send_byte(8'h55);
        chk("R10 byte in read ignored", rf_addr, 8'h02);
        read_one("R10 read after stray byte");
        stop_x();

        // Random phase.
        for (int t = 0; t < 400; t++) begin
            int kind;
            int n;
            kind = int'($urandom % 10);
            if (kind < 5) begin
                start_x(0);
                n = int'($urandom % 10);
                if (n < 6) send_byte(8'($urandom % 39));
                else if (n < 8) send_byte(8'(8'h20 + ($urandom % 7)));
                else send_byte(8'(8'h27 + ($urandom % 25)));
                n = int'($urandom % 7);
                for (int k = 0; k < n; k++) send_byte(8'($urandom));
            end else if (kind < 9) begin
                start_x(1);
                n = 1 + int'($urandom % 5);
                for (int k = 0; k < n; k++) read_one("R5 random read");
            end else begin
                send_byte(8'($urandom));
                read_one("R10 random stray");
            end
            if (($urandom % 10) < 7) stop_x();
            chk("R3 random pointer", rf_addr, exp_ptr);
        end
        stop_x();

        // R7: whole register file matches expectation.
        for (int i = 0; i < 256; i++) begin
            chk("R7 final contents", rf_model[i], exp_mem[i]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule